// File: doc/BRIEF.md
# Ramp-and-Freeze Threshold Sampler

This block turns an externally set analog level into a stored digital code by ramping. On a start request it clears an internal counter and steps it upward once per step tick. The counter feeds an external DAC. An external comparator reports when the DAC output has reached or passed the sensed voltage. The block then freezes the counter, and the frozen code stays in a register for as long as bias is good. Because the value is digital, it does not droop while it is held. Conversion time grows with the level being captured. It is bounded by one full-scale sweep: if the comparator never trips, the code stops at full scale and the block reports done.

While a sample is in progress, the block raises an inhibit output. This output holds the low-side gate driver off and lets a fixed sense current set the voltage being measured. If bias is lost, the block clears the stored code and returns to idle. A start request is honoured only while bias is good and no sample is running.

Top module: `thr_sampler`

## Requirements
- R1: After reset, and on the clock edge after any cycle with `bias_ok` low, `code` is 0 and `busy` and `done` are both 0.
- R2: A `start` pulse while `bias_ok` is high and `busy` is low makes `busy` 1, `done` 0 and `code` 0 on the next edge.
- R3: While busy, a cycle with `step_tick` high and `cmp_trip` low raises `code` by exactly 1 on the next edge, provided `code` is below full scale (2^CODE_W-1).
- R4: While busy, a cycle with `cmp_trip` high ends the sample on the next edge: `busy` falls, `done` rises and `code` keeps its value.
- R5: While busy, a `step_tick` at full scale with `cmp_trip` low ends the sample with `code` at full scale and `done` high. With a tick every cycle, the maximum conversion is 2^CODE_W cycles after the start edge.
- R6: While not busy and with `bias_ok` high, `code` and `done` do not change for any `step_tick` or `cmp_trip` activity.
- R7: A `start` pulse while `busy` is high is ignored: the ramp continues and `code` is not cleared.
- R8: `gate_inhibit` is high in exactly the cycles in which `busy` is high.
- R9: `start` has no effect while `bias_ok` is low.
- R10: When `cmp_trip` and `step_tick` are both high in the same busy cycle, the trip wins and `code` does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_ok | input | 1 | High while supply bias is above its power-on threshold |
| start | input | 1 | Request to begin a new sample |
| cmp_trip | input | 1 | External comparator: DAC output at or above the sensed level |
| step_tick | input | 1 | Ramp step strobe, one counter step per high cycle |
| code | output | CODE_W | Ramp code that drives the DAC; the held result after done |
| busy | output | 1 | Sample in progress |
| done | output | 1 | Sample complete, code is held |
| gate_inhibit | output | 1 | Keeps the low-side driver off and the sense current on during sampling |

## Verification
Every output comes from a register, so each stimulus shows up at the ports one edge after the cycle in which it is driven. The bench drives inputs at the falling edge and reads outputs at the following falling edge. The comparator is modelled as `code >= level`, computed from the `code` output, so a trip is acted on one edge after the matching code appears. With a tick every cycle, the bench therefore expects `done` at the falling edge min(level, full scale)+2 after `start` was driven. It sweeps every level from 0 to one above full scale and checks both that latency and the held code.

// File: rtl/thr_sampler_pkg.sv
package thr_sampler_pkg;

    typedef enum logic [1:0] {
        SMP_IDLE = 2'd0,
        SMP_RAMP = 2'd1,
        SMP_HOLD = 2'd2
    } smp_state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } ramp_ctl_t;

    function automatic logic code_is_full(input logic [15:0] c, input int unsigned w);
        logic [15:0] full;
        full = (16'd1 << w) - 16'd1;
        return c == full;
    endfunction

endpackage

// File: rtl/thr_ramp_cnt.sv
module thr_ramp_cnt
    import thr_sampler_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_ctl_t         ctl,
    output logic [CODE_W-1:0] code,
    output logic              at_full
);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            code <= '0;
        end else if (ctl.inc && code != FULL) begin
            code <= code + 1'b1;
        end
    end

    assign at_full = code_is_full(16'(code), CODE_W);

    // A plain increment never wraps to zero
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (code == FULL && !ctl.clr) |=> code == FULL);

endmodule

// File: rtl/thr_seq_ctrl.sv
module thr_seq_ctrl
    import thr_sampler_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bias_ok,
    input  logic              start,
    input  logic              cmp_trip,
    input  logic              step_tick,
    input  logic              at_full,
    input  logic [CODE_W-1:0] code,
    output ramp_ctl_t         ctl,
    output logic              busy,
    output logic              done
);
    smp_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        ctl       = '0;
        if (!bias_ok) begin
            state_nxt = SMP_IDLE;
            ctl.clr   = 1'b1;
        end else begin
            unique case (state)
                SMP_IDLE, SMP_HOLD: begin
                    if (start) begin
                        state_nxt = SMP_RAMP;
                        ctl.clr   = 1'b1;
                    end
                end
                SMP_RAMP: begin
                    if (cmp_trip) begin
                        state_nxt = SMP_HOLD;
                    end else if (step_tick) begin
                        if (at_full) state_nxt = SMP_HOLD;
                        else         ctl.inc   = 1'b1;
                    end
                end
                default: state_nxt = SMP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SMP_IDLE;
        else     state <= state_nxt;
    end

    assign busy = (state == SMP_RAMP);
    assign done = (state == SMP_HOLD);

    assert_bias_loss_R1: assert property (@(posedge clk) disable iff (rst)
        !bias_ok |=> (code == '0 && !busy && !done));

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (bias_ok && start && !busy) |=> (busy && !done && code == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (bias_ok && busy && step_tick && !cmp_trip && !at_full) |=> code == $past(code) + 1'b1);

    assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (bias_ok && busy && cmp_trip) |=> (done && !busy && code == $past(code)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (bias_ok && !busy && !start) |=> (code == $past(code) && done == $past(done)));

    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        (bias_ok && busy && start && !step_tick && !cmp_trip) |=> (busy && code == $past(code)));

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, done}));

endmodule

// File: rtl/thr_sampler.sv
module thr_sampler
    import thr_sampler_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bias_ok,
    input  logic              start,
    input  logic              cmp_trip,
    input  logic              step_tick,
    output logic [CODE_W-1:0] code,
    output logic              busy,
    output logic              done,
    output logic              gate_inhibit
);
    ramp_ctl_t ctl;
    logic      at_full;

    thr_seq_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk(clk), .rst(rst), .bias_ok(bias_ok), .start(start),
        .cmp_trip(cmp_trip), .step_tick(step_tick), .at_full(at_full),
        .code(code), .ctl(ctl), .busy(busy), .done(done)
    );

    thr_ramp_cnt #(.CODE_W(CODE_W)) u_cnt (
        .clk(clk), .rst(rst), .ctl(ctl), .code(code), .at_full(at_full)
    );

    assign gate_inhibit = busy;

    assert_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> gate_inhibit);

endmodule

// File: tb/thr_sampler_test.sv
module thr_sampler_test;
    localparam int W    = 6;
    localparam int FULL = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst, bias_ok, start, step_tick, cmp_trip;
    logic [W-1:0] code;
    logic         busy, done, gate_inhibit;
    int           level;
    int           checks = 0;
    int           fails  = 0;
    int           cyc    = 0;
    bit           ended  = 1'b0;

    always #5 clk = ~clk;

    // DAC + comparator model: trips once the DAC code reaches the sensed level
    always_comb cmp_trip = (int'(code) >= level);

    thr_sampler #(.CODE_W(W)) uut (
        .clk(clk), .rst(rst), .bias_ok(bias_ok), .start(start),
        .cmp_trip(cmp_trip), .step_tick(step_tick), .code(code),
        .busy(busy), .done(done), .gate_inhibit(gate_inhibit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    // Start a conversion with a tick every cycle; return the falling-edge count to done
    task automatic convert(input int lvl, output int lat);
        @(negedge clk);
        level = lvl; start = 1'b1; step_tick = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk("R2 busy after start", int'(busy), 1);
        chk("R8 inhibit during sample", int'(gate_inhibit), 1);
        while (!done && lat < 200) begin
            chk("R8 inhibit tracks busy", int'(gate_inhibit), int'(busy));
            @(negedge clk);
            lat++;
        end
        step_tick = 1'b0;
    endtask

    initial begin
        int lat, exp_code, held;
        rst = 1'b1; bias_ok = 1'b1; start = 1'b0; step_tick = 1'b0; level = 1000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset code", int'(code), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset done", int'(done), 0);

        // Sweep every level, including one beyond full scale (R3, R4, R5, R10)
        for (int l = 0; l <= FULL + 1; l++) begin
            convert(l, lat);
            exp_code = (l < FULL) ? l : FULL;
            chk(l > FULL ? "R5 saturated code" : "R4 frozen code", int'(code), exp_code);
            chk("R3 latency", lat, exp_code + 2);
            if (l == 0) chk("R10 trip beats tick", int'(code), 0);
        end

        // R6: held value ignores ticks and comparator activity
        convert(23, lat);
        held = int'(code);
        step_tick = 1'b1;
        for (int i = 0; i < 20; i++) begin
            level = (i % 2) ? 0 : 1000;
            @(negedge clk);
        end
        step_tick = 1'b0;
        chk("R6 held code", int'(code), held);
        chk("R6 done kept", int'(done), 1);

        // R7: start while busy is ignored
        @(negedge clk);
        level = 1000; start = 1'b1; step_tick = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        step_tick = 1'b0;
        @(negedge clk);
        chk("R3 ten steps", int'(code), 10);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R7 code kept", int'(code), 10);
        chk("R7 still busy", int'(busy), 1);

        // R3 with sparse ticks: every third cycle
        for (int i = 0; i < 15; i++) begin
            step_tick = (i % 3 == 0);
            @(negedge clk);
        end
        step_tick = 1'b0;
        @(negedge clk);
        chk("R3 sparse ticks", int'(code), 15);

        // R1: bias loss mid-sample clears everything
        bias_ok = 1'b0;
        @(negedge clk);
        chk("R1 bias loss code", int'(code), 0);
        chk("R1 bias loss busy", int'(busy), 0);
        chk("R8 inhibit off", int'(gate_inhibit), 0);

        // R9: start ignored while bias is low
        start = 1'b1; step_tick = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R9 no busy", int'(busy), 0);
        chk("R9 no code", int'(code), 0);
        step_tick = 1'b0;
        bias_ok = 1'b1;

        // Restart after recovery
        convert(7, lat);
        chk("R2 restart code", int'(code), 7);

        finish_run();
    end
endmodule